// File: doc/BRIEF.md
# Serial Flash Sequential Byte-Program Engine

This block is the slave-side command engine of a serial-attached flash array that talks SPI mode 0. It decodes four kinds of frame: set write-enable, clear write-enable, status read, and a streaming byte-program command. The first streaming frame carries a start address and a data byte. Each later frame carries only the opcode and one more data byte, which goes to the next address. No fresh write-enable is needed between these frames. Each accepted frame ends with chip-select rising, and then one byte-program request goes to an array port. The port uses a request / done / fail handshake, and the engine holds a busy flag until done returns.

The serial pins are sampled with the system clock, so the serial clock must run well below it. Protection comes in as one lock bit per sector over a non-uniform sector map. The streaming mode never wraps and never skips a locked sector. It ends itself after the last byte of the array and after the last byte below a locked sector. A malformed frame aborts the mode and drops write-enable.

Top module: `sfp_seq_prog`

## Requirements
- R1: Opcode 06h (one whole byte) sets write-enable (status bit 1); opcode 04h clears write-enable and ends the streaming mode.
- R2: With write-enable set, a frame of opcode ADh or AFh, a 24-bit address (MSB first) and a data byte issues one program request for that address and byte at chip-select release.
- R3: While the streaming mode is active, each frame of ADh or AFh plus one data byte programs the address one above the previous one, without a new write-enable.
- R4: When several whole data bytes arrive in one streaming frame, only the last one is programmed.
- R5: A streaming frame that ends on a bit count that is not a multiple of eight, or before a whole data byte has arrived, programs nothing, clears write-enable and ends the mode.
- R6: A first streaming frame whose address lies in a locked sector programs nothing, clears write-enable and leaves the engine idle.
- R7: After programming the last byte below a locked sector, the mode ends and write-enable clears once the program completes.
- R8: After programming the top byte of the array, the mode ends and write-enable clears; the address never wraps.
- R9: The sector map, counted from address 0, is 64 KB sectors up to the top 64 KB, then one 32 KB, two 8 KB and one 16 KB sector (sectors 0..10 for a 512 KB array).
- R10: Opcode 05h returns the status byte MSB first on falling serial-clock edges: bit 0 busy (set from request until done), bit 1 write-enable, bit 5 program failure, other bits 0.
- R11: The program-failure bit sets when the array reports done with fail, and clears when the next program request starts.
- R12: Frames other than a status read that end while busy are ignored; a streaming frame while write-enable is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status) |
| sec_lock | input | NSEC | Per-sector lock bits, bit n for sector n |
| pgm_req | output | 1 | One-cycle byte-program request |
| pgm_addr | output | ADDR_W | Byte address of the request |
| pgm_data | output | 8 | Byte to program |
| pgm_done | input | 1 | Array finished the current byte |
| pgm_fail | input | 1 | Valid with done: the byte failed |

## Verification
The bench builds the engine with its default ADDR_W of 19, which gives a 512 KB array and eleven sectors. At this size the real top address 07FFFFh and the non-uniform boundaries near the top can be reached directly, including the 32 KB to 8 KB step and the 8 KB to 8 KB step. Start addresses are placed one byte below these boundaries. This shows whether the mode runs on into an unlocked sector and stops in front of a locked one. It also shows that the array end ends the run.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SEQA = 8'hAD;
  localparam logic [7:0] OP_SEQB = 8'hAF;

  localparam int STS_BUSY = 0;
  localparam int STS_WEL  = 1;
  localparam int STS_EPE  = 5;

  // Sector count for a 2**aw byte array (aw >= 17).
  function automatic int unsigned num_sectors(int unsigned aw);
    return (32'd1 << (aw - 32'd16)) + 32'd3;
  endfunction

  // Sector index of a byte address: 64 KB sectors below the top 64 KB,
  // which splits into 32 KB, 8 KB, 8 KB, 16 KB.
  function automatic int unsigned sector_of(logic [23:0] a, int unsigned aw);
    logic [24:0] top;
    logic [24:0] ax;
    int unsigned ns;
    top = 25'd1 << aw;
    ax  = {1'b0, a};
    ns  = num_sectors(aw);
    if (ax >= top - 25'h04000)      return ns - 32'd1;
    else if (ax >= top - 25'h06000) return ns - 32'd2;
    else if (ax >= top - 25'h08000) return ns - 32'd3;
    else if (ax >= top - 25'h10000) return ns - 32'd4;
    else                            return 32'(a[23:16]);
  endfunction
endpackage

// File: rtl/sfp_spi_rx.sv
module sfp_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       frame_start,
  output logic       frame_end,
  output logic       sck_fall,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [2:0] bit_phase,
  output logic [2:0] byte_idx
);
  logic       sclk_d, cs_d;
  logic [7:0] sr;
  logic       sck_rise;

  assign frame_start = ~cs_n & cs_d;
  assign frame_end   = cs_n & ~cs_d;
  assign sck_rise    = sclk & ~sclk_d & ~cs_n;
  assign sck_fall    = ~sclk & sclk_d & ~cs_n;
  assign byte_done   = sck_rise && (bit_phase == 3'd7);
  assign rx_byte     = {sr[6:0], mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      sr        <= '0;
      bit_phase <= '0;
      byte_idx  <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (frame_start) begin
        bit_phase <= '0;
        byte_idx  <= '0;
      end else if (sck_rise) begin
        sr        <= {sr[6:0], mosi};
        bit_phase <= bit_phase + 3'd1;
        if (bit_phase == 3'd7 && byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/sfp_prot_lookup.sv
module sfp_prot_lookup #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned NSEC   = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSEC-1:0]   lock,
  output logic              locked
);
  logic [NSEC-1:0] hit;
  int unsigned     idx;

  assign idx = sfp_pkg::sector_of(24'(addr), ADDR_W);

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign hit[s] = (idx == 32'(s));
  end

  assign locked = |(hit & lock);
endmodule

// File: rtl/sfp_seq_ctrl.sv
module sfp_seq_ctrl #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned NSEC   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sck_fall,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [2:0]        bit_phase,
  input  logic [2:0]        byte_idx,
  input  logic [NSEC-1:0]   sec_lock,
  input  logic              pgm_done,
  input  logic              pgm_fail,
  output logic              miso,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              issue_evt,
  output logic              abort_evt,
  output logic              deny_evt,
  output logic              wrdi_evt,
  output logic              sts_busy,
  output logic              sts_wel,
  output logic              sts_epe
);
  import sfp_pkg::*;

  logic [7:0]        opcode, data_q;
  logic [23:0]       addr_fr;
  logic [ADDR_W-1:0] cur_addr, target, nxt;
  logic              data_ok, seq_q, end_q;
  logic              busy_q, wel_q, epe_q;
  logic              lock_tgt, lock_nxt;
  logic              is_seq, fe_live, seq_frame, good_frame, wren_evt, done_evt;
  logic [7:0]        status;

  assign target = seq_q ? cur_addr : addr_fr[ADDR_W-1:0];
  assign nxt    = target + ADDR_W'(1);

  sfp_prot_lookup #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_lk_tgt (
    .addr(target), .lock(sec_lock), .locked(lock_tgt));
  sfp_prot_lookup #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_lk_nxt (
    .addr(nxt), .lock(sec_lock), .locked(lock_nxt));

  assign is_seq     = (opcode == OP_SEQA) || (opcode == OP_SEQB);
  assign fe_live    = frame_end && (byte_idx != 3'd0) && !busy_q;
  assign wren_evt   = fe_live && (bit_phase == 3'd0) && (opcode == OP_WREN);
  assign wrdi_evt   = fe_live && (bit_phase == 3'd0) && (opcode == OP_WRDI);
  assign seq_frame  = fe_live && is_seq && wel_q;
  assign good_frame = seq_frame && (bit_phase == 3'd0) && data_ok;
  assign abort_evt  = seq_frame && !good_frame;
  assign deny_evt   = good_frame && lock_tgt;
  assign issue_evt  = good_frame && !lock_tgt;
  assign done_evt   = busy_q && pgm_done;

  always_comb begin
    status           = '0;
    status[STS_BUSY] = busy_q;
    status[STS_WEL]  = wel_q;
    status[STS_EPE]  = epe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= '0;
      data_q   <= '0;
      addr_fr  <= '0;
      cur_addr <= '0;
      data_ok  <= 1'b0;
      seq_q    <= 1'b0;
      end_q    <= 1'b0;
      busy_q   <= 1'b0;
      wel_q    <= 1'b0;
      epe_q    <= 1'b0;
      pgm_req  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
      miso     <= 1'b0;
    end else begin
      pgm_req <= issue_evt;
      if (frame_start) data_ok <= 1'b0;
      if (byte_done) begin
        if (byte_idx == 3'd0) opcode <= rx_byte;
        else if (is_seq) begin
          if (!seq_q && byte_idx <= 3'd3) addr_fr <= {addr_fr[15:0], rx_byte};
          else begin
            data_q  <= rx_byte;
            data_ok <= 1'b1;
          end
        end
      end
      if (wren_evt) wel_q <= 1'b1;
      if (wrdi_evt || abort_evt || deny_evt) begin
        wel_q <= 1'b0;
        seq_q <= 1'b0;
      end
      if (issue_evt) begin
        seq_q    <= 1'b1;
        busy_q   <= 1'b1;
        epe_q    <= 1'b0;
        cur_addr <= nxt;
        end_q    <= (&target) || lock_nxt;
        pgm_addr <= target;
        pgm_data <= data_q;
      end
      if (done_evt) begin
        busy_q <= 1'b0;
        if (pgm_fail) epe_q <= 1'b1;
        if (end_q) begin
          wel_q <= 1'b0;
          seq_q <= 1'b0;
        end
      end
      if (frame_end) miso <= 1'b0;
      else if (sck_fall)
        miso <= (opcode == OP_RDSR && byte_idx != 3'd0) ? status[~bit_phase] : 1'b0;
    end
  end

  assign sts_busy = busy_q;
  assign sts_wel  = wel_q;
  assign sts_epe  = epe_q;
endmodule

// File: rtl/sfp_seq_prog.sv
module sfp_seq_prog #(
  parameter int unsigned ADDR_W = 19,
  localparam int unsigned NSEC  = sfp_pkg::num_sectors(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [NSEC-1:0]   sec_lock,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  input  logic              pgm_done,
  input  logic              pgm_fail
);
  logic       frame_start, frame_end, sck_fall, byte_done;
  logic [7:0] rx_byte;
  logic [2:0] bit_phase, byte_idx;
  logic       issue_evt, abort_evt, deny_evt, wrdi_evt;
  logic       sts_busy, sts_wel, sts_epe;

  sfp_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame_start(frame_start), .frame_end(frame_end), .sck_fall(sck_fall),
    .byte_done(byte_done), .rx_byte(rx_byte), .bit_phase(bit_phase), .byte_idx(byte_idx));

  sfp_seq_ctrl #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .sck_fall(sck_fall), .byte_done(byte_done), .rx_byte(rx_byte),
    .bit_phase(bit_phase), .byte_idx(byte_idx), .sec_lock(sec_lock),
    .pgm_done(pgm_done), .pgm_fail(pgm_fail), .miso(spi_miso),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .issue_evt(issue_evt), .abort_evt(abort_evt), .deny_evt(deny_evt),
    .wrdi_evt(wrdi_evt), .sts_busy(sts_busy), .sts_wel(sts_wel), .sts_epe(sts_epe));
endmodule

// File: rtl/sfp_seq_prog_chk.sv
module sfp_seq_prog_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned NSEC   = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pgm_req,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic              pgm_done,
  input logic              pgm_fail,
  input logic [NSEC-1:0]   sec_lock,
  input logic              issue_evt,
  input logic              abort_evt,
  input logic              deny_evt,
  input logic              wrdi_evt,
  input logic              sts_busy,
  input logic              sts_wel,
  input logic              sts_epe
);
  int unsigned req_sec;
  assign req_sec = sfp_pkg::sector_of(24'(pgm_addr), ADDR_W);

  // R2
  req_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> pgm_req);
  // R10
  busy_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> sts_busy);
  // R12
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);
  // R5
  abort_drops_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !sts_wel);
  // R6
  deny_drops_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |=> (!sts_wel && !pgm_req));
  // R1
  wrdi_drops_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi_evt |=> !sts_wel);
  // R11
  epe_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_busy && pgm_done && pgm_fail) |=> sts_epe);
  // R7
  req_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> !sec_lock[req_sec]);
endmodule

bind sfp_seq_prog sfp_seq_prog_chk #(.ADDR_W(ADDR_W), .NSEC(NSEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
  .pgm_done(pgm_done), .pgm_fail(pgm_fail), .sec_lock(sec_lock),
  .issue_evt(issue_evt), .abort_evt(abort_evt), .deny_evt(deny_evt),
  .wrdi_evt(wrdi_evt), .sts_busy(sts_busy), .sts_wel(sts_wel), .sts_epe(sts_epe));

// File: tb/sfp_seq_prog_tb.sv
module sfp_seq_prog_tb;
  localparam int unsigned ADDR_W = 19;
  localparam int unsigned NSEC   = 11;
  localparam int HP      = 4;
  localparam int ARR_LAT = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [NSEC-1:0] sec_lock = '0;
  logic pgm_req;
  logic [ADDR_W-1:0] pgm_addr;
  logic [7:0] pgm_data;
  logic pgm_done = 1'b0, pgm_fail = 1'b0;
  logic fail_mode = 1'b0;

  int n_chk = 0, n_fail = 0, n_req = 0;
  logic [ADDR_W+7:0] exp_q[$];

  always #10 clk = ~clk;

  sfp_seq_prog #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sec_lock(sec_lock),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_done(pgm_done), .pgm_fail(pgm_fail));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Array model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pgm_req) begin
        n_req++;
        if (exp_q.size() == 0)
          check(1'b0, "R12 unexpected program request", int'({pgm_addr, pgm_data}), 0);
        else begin
          logic [ADDR_W+7:0] e;
          e = exp_q.pop_front();
          check({pgm_addr, pgm_data} == e, "R2/R3/R4 program addr+data",
                int'({pgm_addr, pgm_data}), int'(e));
        end
        repeat (ARR_LAT) @(negedge clk);
        pgm_done = 1'b1;
        pgm_fail = fail_mode;
        @(negedge clk);
        pgm_done = 1'b0;
        pgm_fail = 1'b0;
      end
    end
  end

  task automatic clk_bit(input logic b, output logic so);
    spi_mosi = b;
    spi_sclk = 1'b0;
    repeat (HP) @(negedge clk);
    so = spi_miso;
    spi_sclk = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic so;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], so);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_high();
    spi_sclk = 1'b0;
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    cs_low(); send_byte(op); cs_high();
  endtask

  task automatic seq_first(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    cs_low(); send_byte(op); send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(d); cs_high();
  endtask

  task automatic seq_next(input logic [7:0] op, input logic [7:0] d);
    cs_low(); send_byte(op); send_byte(d); cs_high();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic so;
    cs_low();
    send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, so);
      s[i] = so;
    end
    cs_high();
  endtask

  task automatic chk_sts(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    rd_status(s);
    check(s == exp, tag, int'(s), int'(exp));
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic expect_pgm(input logic [23:0] a, input logic [7:0] d);
    exp_q.push_back({a[ADDR_W-1:0], d});
  endtask

  task automatic chk_reqs(input int exp, input string tag);
    check(n_req == exp, tag, n_req, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pgm_req == 1'b0, "R2 reset: no request", int'(pgm_req), 0);
    chk_sts(8'h00, "R10 reset status");

    // R1 write enable
    op1(8'h06);
    chk_sts(8'h02, "R1 WEL set by 06h");

    // R2 first frame, R10 busy during program
    expect_pgm(24'h001000, 8'h5A);
    seq_first(8'hAD, 24'h001000, 8'h5A);
    chk_sts(8'h03, "R10 busy while programming");
    wait_idle();
    chk_sts(8'h02, "R2 idle after first byte, WEL kept");

    // R3 continuation, R4 last byte wins
    expect_pgm(24'h001001, 8'h11);
    seq_next(8'hAF, 8'h11);
    wait_idle();
    expect_pgm(24'h001002, 8'h33);
    cs_low(); send_byte(8'hAD); send_byte(8'h22); send_byte(8'h33); cs_high();
    wait_idle();
    chk_reqs(3, "R3/R4 request count");

    // R5 partial byte abort
    cs_low(); send_byte(8'hAD);
    begin logic so; for (int i = 0; i < 4; i++) clk_bit(1'b1, so); end
    cs_high();
    chk_sts(8'h00, "R5 partial frame clears WEL");
    // R12 streaming frame without WEL ignored
    seq_next(8'hAD, 8'h44);
    repeat (ARR_LAT) @(negedge clk);
    chk_reqs(3, "R5/R12 no request after abort");

    // R5 no data byte
    op1(8'h06);
    cs_low(); send_byte(8'hAD); send_byte(8'h00); send_byte(8'h20); send_byte(8'h00); cs_high();
    chk_sts(8'h00, "R5 missing data clears WEL");

    // R6 locked start
    sec_lock = 11'b000_0000_0010;
    op1(8'h06);
    seq_first(8'hAD, 24'h010000, 8'h77);
    chk_sts(8'h00, "R6 locked start clears WEL");
    chk_reqs(3, "R6 no request on locked start");

    // R7 stop below locked sector 1
    op1(8'h06);
    expect_pgm(24'h00FFFE, 8'hA1);
    seq_first(8'hAF, 24'h00FFFE, 8'hA1);
    wait_idle();
    chk_sts(8'h02, "R7 continues inside sector");
    expect_pgm(24'h00FFFF, 8'hA2);
    seq_next(8'hAF, 8'hA2);
    wait_idle();
    chk_sts(8'h00, "R7 mode ends below locked sector");
    seq_next(8'hAF, 8'hA3);
    repeat (ARR_LAT) @(negedge clk);
    chk_reqs(5, "R7 no request after end");

    // R9 non-uniform map: sector 7 (32K) -> 8 (8K) crossing, sector 9 locked
    sec_lock = 11'b010_0000_0000;
    op1(8'h06);
    expect_pgm(24'h077FFF, 8'hB1);
    seq_first(8'hAD, 24'h077FFF, 8'hB1);
    wait_idle();
    chk_sts(8'h02, "R9 crossing into unlocked 8K sector continues");
    expect_pgm(24'h078000, 8'hB2);
    seq_next(8'hAD, 8'hB2);
    wait_idle();
    op1(8'h04);
    op1(8'h06);
    expect_pgm(24'h079FFF, 8'hB3);
    seq_first(8'hAD, 24'h079FFF, 8'hB3);
    wait_idle();
    chk_sts(8'h00, "R9 stop at 8K sector 9 boundary");
    sec_lock = 11'b100_0000_0000;
    op1(8'h06);
    expect_pgm(24'h07BFFF, 8'hB4);
    seq_first(8'hAD, 24'h07BFFF, 8'hB4);
    wait_idle();
    chk_sts(8'h00, "R9 stop below 16K top sector");

    // R8 top of array
    sec_lock = '0;
    op1(8'h06);
    expect_pgm(24'h07FFFF, 8'hC1);
    seq_first(8'hAD, 24'h07FFFF, 8'hC1);
    wait_idle();
    chk_sts(8'h00, "R8 mode ends at top byte");
    seq_next(8'hAD, 8'hC2);
    repeat (ARR_LAT) @(negedge clk);
    chk_reqs(10, "R8 no wrap request");

    // R1 write disable ends mode
    op1(8'h06);
    expect_pgm(24'h003000, 8'hD1);
    seq_first(8'hAD, 24'h003000, 8'hD1);
    wait_idle();
    op1(8'h04);
    chk_sts(8'h00, "R1 04h clears WEL");
    op1(8'h06);
    seq_next(8'hAD, 8'hD2);
    chk_sts(8'h00, "R1 mode ended by 04h (frame aborts)");
    chk_reqs(11, "R1 no request after 04h");

    // R11 failure flag
    op1(8'h06);
    fail_mode = 1'b1;
    expect_pgm(24'h004000, 8'hE1);
    seq_first(8'hAD, 24'h004000, 8'hE1);
    wait_idle();
    chk_sts(8'h22, "R11 failure flag set");
    fail_mode = 1'b0;
    expect_pgm(24'h004001, 8'hE2);
    seq_next(8'hAD, 8'hE2);
    chk_sts(8'h03, "R11 failure flag cleared at next request");
    wait_idle();

    // R12 commands ignored while busy
    expect_pgm(24'h004002, 8'hF1);
    seq_next(8'hAF, 8'hF1);
    op1(8'h04);
    wait_idle();
    chk_sts(8'h02, "R12 04h ignored while busy");
    op1(8'h04);

    repeat (ARR_LAT) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected programs seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule